// File: doc/BRIEF.md
# Interleaved Dual-Ramp PWM Timer

This block is a single-slope, up-counting PWM timer whose successive counter cycles are labelled ramp A and ramp B. In the normal mode it is a plain compare-based PWM generator. In the three dual-ramp modes, the ramp index decides which outputs may be active. Even-numbered outputs can only be active in ramp A, and odd-numbered outputs only in ramp B. This lets two interleaved phases of a power converter be driven from one counter.

The mode also changes what the period and compare registers mean. In the standard mode, a circular option swaps the period with its buffer at each wrap, so the two ramps can have different lengths. In the alternate mode with the circular option, compare 0 drives both output 0 and output 1. In the critical mode, compare 0 is the top of ramp A and the period register is the top of ramp B. Output 0 is then set at compare 2 and cleared at compare 0. With only two channels, output 0 covers the whole of ramp A.

The ramp index is a two-state machine with states RAMP_A and RAMP_B. It moves only at an update, the cycle in which the count reaches its top. At that moment the index command picks one of four transitions:
- TOGGLE (command 0)
- FORCE_A (command 1)
- FORCE_B (command 2)
- HOLD (command 3)

Period and compare values are written through single-cycle write ports into buffers. The buffers are copied to the active registers at each update.

Top module: `ramp_pwm_timer`

## Requirements
- R1: While reset is asserted, the count is 0, the ramp index is A (ramp_idx = 0), upd is 0 and every output sits at its inactive level.
- R2: In mode 0 (normal), output i is active while the count is below active compare i, and ramp gating does not apply.
- R3: The count steps by one each clock from 0 up to the current top. upd is high exactly in the cycle in which the count equals the top, and the count is 0 in the next cycle. Values written to the period and compare buffers become active at that update, so with the reset period of 7 a ramp lasts 8 cycles.
- R4: When an update occurs with idx_cmd = 0, the ramp index toggles. Without an update, the ramp index does not change.
- R5: idx_cmd is sampled at an update. Code 1 makes the next ramp A, code 2 makes it B, and code 3 keeps the current index.
- R6: In modes 1, 2 and 3 (dual-ramp), odd-numbered outputs are forced inactive during ramp A, and even-numbered outputs are forced inactive during ramp B.
- R7: In mode 1 or 2 with circ_en = 1, the active period and its buffer swap at every update, so ramp A and ramp B alternate between two lengths.
- R8: In mode 2 with circ_en = 1, output 1 is active while the count is below compare 0, and it uses polarity bit 0.
- R9: In mode 3 (critical), the top of ramp A is active compare 0 and the top of ramp B is the active period.
- R10: In mode 3 with more than two channels, output 0 is active while compare 2 <= count < compare 0. With two channels, output 0 is active for the whole of ramp A.
- R11: Each output equals its gated raw level XOR its polarity bit, so the inactive level equals the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 normal, 1 standard dual, 2 alternate dual, 3 critical dual |
| circ_en | input | 1 | Circular period / shared-compare option |
| pol | input | NCH | Per-output polarity (1 inverts) |
| idx_cmd | input | 2 | Ramp index command applied at the next update |
| per_wr | input | 1 | Write strobe for the period buffer |
| per_wdata | input | CNT_W | Period buffer write data |
| cc_wr | input | NCH | Per-channel write strobes for the compare buffers |
| cc_wdata | input | CNT_W | Compare buffer write data |
| wo | output | NCH | Waveform outputs |
| ramp_idx | output | 1 | Current ramp index (0 = A, 1 = B) |
| upd | output | 1 | Update pulse at each counter wrap |

## Verification
A table of configurations runs each mode under a cycle-by-cycle reference model. The normal mode is run with compares below, inside and above the period, which tells the compare threshold apart from the wrap point. The dual modes are run both with and without the circular option, which separates plain gating from period swapping and from compare 0 being shared onto output 1. The critical mode is run with both polarities and with a second, two-channel instance, which tells the compare-2 set point apart from the full-ramp-A pulse. Directed tests then measure ramp lengths between update pulses and drive each index command.

// File: rtl/ramp_pwm_pkg.sv
package ramp_pwm_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE    = 2'd0,
        MODE_DUAL_STD  = 2'd1,
        MODE_DUAL_ALT  = 2'd2,
        MODE_DUAL_CRIT = 2'd3
    } ramp_mode_e;

    typedef enum logic {
        RAMP_A = 1'b0,
        RAMP_B = 1'b1
    } ramp_e;

    typedef enum logic [1:0] {
        IDX_TOGGLE  = 2'd0,
        IDX_FORCE_A = 2'd1,
        IDX_FORCE_B = 2'd2,
        IDX_HOLD    = 2'd3
    } idx_cmd_e;
endpackage

// File: rtl/ramp_pwm_regs.sv
module ramp_pwm_regs
    import ramp_pwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NCH     = 4,
    parameter int PER_RST = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       upd,
    input  logic                       swap_en,
    input  logic                       per_wr,
    input  logic [CNT_W-1:0]           per_wdata,
    input  logic [NCH-1:0]             cc_wr,
    input  logic [CNT_W-1:0]           cc_wdata,
    output logic [CNT_W-1:0]           per_act,
    output logic [NCH-1:0][CNT_W-1:0]  cc_act
);
    localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(PER_RST);

    logic [CNT_W-1:0] per_buf;

    // Period: buffer copied at update; circular option hands old period back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act <= PER_INIT;
            per_buf <= PER_INIT;
        end else begin
            if (upd) begin
                per_act <= per_buf;
                if (swap_en) per_buf <= per_act;
            end
            if (per_wr) per_buf <= per_wdata;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cc
        logic [CNT_W-1:0] cc_buf;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cc_buf    <= '0;
                cc_act[i] <= '0;
            end else begin
                if (upd)      cc_act[i] <= cc_buf;
                if (cc_wr[i]) cc_buf    <= cc_wdata;
            end
        end
    end
endmodule

// File: rtl/ramp_pwm_ctrl.sv
module ramp_pwm_ctrl
    import ramp_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ramp_mode_e       mode,
    input  idx_cmd_e         idx_cmd,
    input  logic [CNT_W-1:0] per_act,
    input  logic [CNT_W-1:0] cc0_act,
    output logic [CNT_W-1:0] cnt,
    output ramp_e            state,
    output logic             upd
);
    ramp_e            state_nxt;
    logic [CNT_W-1:0] top;

    always_comb begin
        top = (mode == MODE_DUAL_CRIT && state == RAMP_A) ? cc0_act : per_act;
        upd = (cnt >= top);
    end

    // Index transitions: TOGGLE, FORCE_A, FORCE_B, HOLD, taken only at update.
    always_comb begin
        state_nxt = state;
        unique case (state)
            RAMP_A: if (upd) begin
                unique case (idx_cmd)
                    IDX_TOGGLE:  state_nxt = RAMP_B;
                    IDX_FORCE_A: state_nxt = RAMP_A;
                    IDX_FORCE_B: state_nxt = RAMP_B;
                    IDX_HOLD:    state_nxt = RAMP_A;
                endcase
            end
            RAMP_B: if (upd) begin
                unique case (idx_cmd)
                    IDX_TOGGLE:  state_nxt = RAMP_A;
                    IDX_FORCE_A: state_nxt = RAMP_A;
                    IDX_FORCE_B: state_nxt = RAMP_B;
                    IDX_HOLD:    state_nxt = RAMP_B;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RAMP_A;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= upd ? '0 : cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ramp_pwm_wave.sv
module ramp_pwm_wave
    import ramp_pwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int NCH   = 4
) (
    input  ramp_mode_e                 mode,
    input  logic                       circ_en,
    input  logic [NCH-1:0]             pol,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [NCH-1:0][CNT_W-1:0]  cc_act,
    input  ramp_e                      ramp_idx,
    output logic [NCH-1:0]             wo
);
    logic crit0;

    if (NCH > 2) begin : g_crit_win
        assign crit0 = (cnt >= cc_act[2]) && (cnt < cc_act[0]);
    end else begin : g_crit_full
        assign crit0 = 1'b1;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic raw, psel, blank;
        always_comb begin
            raw  = cnt < cc_act[i];
            psel = pol[i];
            if (i == 0 && mode == MODE_DUAL_CRIT) raw = crit0;
            if (i == 1 && mode == MODE_DUAL_ALT && circ_en) begin
                raw  = cnt < cc_act[0];
                psel = pol[0];
            end
            blank = (mode != MODE_SINGLE) &&
                    (((i % 2) == 1) ? (ramp_idx == RAMP_A) : (ramp_idx == RAMP_B));
        end
        assign wo[i] = (raw & ~blank) ^ psel;
    end
endmodule

// File: rtl/ramp_pwm_timer.sv
module ramp_pwm_timer
    import ramp_pwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NCH     = 4,
    parameter int PER_RST = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             circ_en,
    input  logic [NCH-1:0]   pol,
    input  logic [1:0]       idx_cmd,
    input  logic             per_wr,
    input  logic [CNT_W-1:0] per_wdata,
    input  logic [NCH-1:0]   cc_wr,
    input  logic [CNT_W-1:0] cc_wdata,
    output logic [NCH-1:0]   wo,
    output logic             ramp_idx,
    output logic             upd
);
    ramp_mode_e                mode_e;
    logic [CNT_W-1:0]          cnt;
    logic [CNT_W-1:0]          per_act;
    logic [NCH-1:0][CNT_W-1:0] cc_act;
    ramp_e                     state;
    logic                      swap_en;

    assign mode_e   = ramp_mode_e'(mode);
    assign swap_en  = circ_en && (mode_e == MODE_DUAL_STD || mode_e == MODE_DUAL_ALT);
    assign ramp_idx = state;

    ramp_pwm_regs #(.CNT_W(CNT_W), .NCH(NCH), .PER_RST(PER_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .upd(upd), .swap_en(swap_en),
        .per_wr(per_wr), .per_wdata(per_wdata),
        .cc_wr(cc_wr), .cc_wdata(cc_wdata),
        .per_act(per_act), .cc_act(cc_act)
    );

    ramp_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .mode(mode_e),
        .idx_cmd(idx_cmd_e'(idx_cmd)),
        .per_act(per_act), .cc0_act(cc_act[0]),
        .cnt(cnt), .state(state), .upd(upd)
    );

    ramp_pwm_wave #(.CNT_W(CNT_W), .NCH(NCH)) u_wave (
        .mode(mode_e), .circ_en(circ_en), .pol(pol), .cnt(cnt),
        .cc_act(cc_act), .ramp_idx(state), .wo(wo)
    );
endmodule

// File: rtl/ramp_pwm_checker.sv
module ramp_pwm_checker #(
    parameter int CNT_W = 8,
    parameter int NCH   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             circ_en,
    input logic [NCH-1:0]   pol,
    input logic [1:0]       idx_cmd,
    input logic [NCH-1:0]   wo,
    input logic             ramp_idx,
    input logic             upd,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cc0
);
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> cnt == '0);

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> cnt == $past(cnt) + CNT_W'(1));

    p_idx_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && idx_cmd == 2'd0) |=> ramp_idx != $past(ramp_idx));

    p_idx_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(ramp_idx));

    p_force_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && idx_cmd == 2'd1) |=> ramp_idx == 1'b0);

    p_force_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && idx_cmd == 2'd2) |=> ramp_idx == 1'b1);

    p_even_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && ramp_idx) |-> wo[0] == pol[0]);

    p_odd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && !ramp_idx && !(mode == 2'd2 && circ_en)) |-> wo[1] == pol[1]);

    p_alt_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && circ_en && !ramp_idx) |-> wo[1] == pol[0]);

    p_crit_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && !ramp_idx && upd) |-> cnt == cc0);
endmodule

bind ramp_pwm_timer ramp_pwm_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .circ_en(circ_en), .pol(pol),
    .idx_cmd(idx_cmd), .wo(wo), .ramp_idx(ramp_idx), .upd(upd),
    .cnt(cnt), .cc0(cc_act[0])
);

// File: tb/sim_ramp_pwm_timer.sv
`timescale 1ns/1ps
module sim_ramp_pwm_timer;
    localparam int W = 8;
    localparam int N = 4;
    localparam int PR = 7;

    typedef struct packed {
        logic [1:0] mode;
        logic       circ;
        logic [7:0] pa, pb, c0, c1, c2, c3;
        logic [3:0] pol;
    } cfg_t;

    localparam cfg_t CFG [8] = '{
        '{2'd0, 1'b0, 8'd9,  8'd9,  8'd3, 8'd5, 8'd0, 8'd10, 4'b0000},
        '{2'd0, 1'b0, 8'd11, 8'd11, 8'd2, 8'd4, 8'd6, 8'd8,  4'b0101},
        '{2'd1, 1'b0, 8'd7,  8'd7,  8'd3, 8'd4, 8'd5, 8'd6,  4'b0000},
        '{2'd1, 1'b1, 8'd5,  8'd9,  8'd2, 8'd3, 8'd4, 8'd5,  4'b0000},
        '{2'd2, 1'b1, 8'd6,  8'd10, 8'd3, 8'd1, 8'd1, 8'd1,  4'b0011},
        '{2'd2, 1'b0, 8'd8,  8'd8,  8'd3, 8'd6, 8'd2, 8'd4,  4'b0000},
        '{2'd3, 1'b0, 8'd12, 8'd12, 8'd8, 8'd5, 8'd3, 8'd6,  4'b0000},
        '{2'd3, 1'b0, 8'd9,  8'd9,  8'd6, 8'd2, 8'd2, 8'd7,  4'b1111}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic circ_en = 1'b0;
    logic [N-1:0] pol = '0;
    logic [1:0] idx_cmd = '0;
    logic per_wr = 1'b0;
    logic [W-1:0] per_wdata = '0;
    logic [N-1:0] cc_wr = '0;
    logic [W-1:0] cc_wdata = '0;
    logic [N-1:0] wo;
    logic ramp_idx, upd;
    logic [1:0] wo2;
    logic ramp_idx2, upd2;

    always #4 clk = ~clk;

    ramp_pwm_timer #(.CNT_W(W), .NCH(N), .PER_RST(PR)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .circ_en(circ_en), .pol(pol),
        .idx_cmd(idx_cmd), .per_wr(per_wr), .per_wdata(per_wdata),
        .cc_wr(cc_wr), .cc_wdata(cc_wdata), .wo(wo), .ramp_idx(ramp_idx), .upd(upd));

    ramp_pwm_timer #(.CNT_W(W), .NCH(2), .PER_RST(PR)) u1 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .circ_en(circ_en), .pol(pol[1:0]),
        .idx_cmd(idx_cmd), .per_wr(per_wr), .per_wdata(per_wdata),
        .cc_wr(cc_wr[1:0]), .cc_wdata(cc_wdata), .wo(wo2), .ramp_idx(ramp_idx2), .upd(upd2));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    int m_cnt, m_per, m_perb;
    int m_cc [N];
    int m_ccb [N];
    bit m_idx;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_top();
        return (mode == 2'd3 && !m_idx) ? m_cc[0] : m_per;
    endfunction

    function automatic logic [N-1:0] m_wo();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            bit raw, p;
            raw = m_cnt < m_cc[i];
            p = pol[i];
            if (i == 0 && mode == 2'd3) raw = (m_cnt >= m_cc[2]) && (m_cnt < m_cc[0]);
            if (i == 1 && mode == 2'd2 && circ_en) begin
                raw = m_cnt < m_cc[0];
                p = pol[0];
            end
            if (mode != 2'd0 && (((i % 2) == 1 && !m_idx) || ((i % 2) == 0 && m_idx))) raw = 0;
            r[i] = raw ^ p;
        end
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        if (m_cnt >= m_top()) begin
            int old;
            old = m_per;
            m_cnt = 0;
            m_per = m_perb;
            if (circ_en && (mode == 2'd1 || mode == 2'd2)) m_perb = old;
            for (int i = 0; i < N; i++) m_cc[i] = m_ccb[i];
            case (idx_cmd)
                2'd0: m_idx = !m_idx;
                2'd1: m_idx = 1'b0;
                2'd2: m_idx = 1'b1;
                default: ;
            endcase
        end else m_cnt++;
        if (per_wr) m_perb = per_wdata;
        for (int i = 0; i < N; i++) if (cc_wr[i]) m_ccb[i] = cc_wdata;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        per_wr = 1'b0;
        cc_wr = '0;
        idx_cmd = 2'd0;
        repeat (2) @(negedge clk);
        m_cnt = 0; m_idx = 0; m_per = PR; m_perb = PR;
        for (int i = 0; i < N; i++) begin m_cc[i] = 0; m_ccb[i] = 0; end
        rst_n = 1'b1;
    endtask

    task automatic wr_per(input int v);
        per_wr = 1'b1; per_wdata = W'(v);
        tick();
        per_wr = 1'b0;
    endtask

    task automatic wr_cc(input int ch, input int v);
        cc_wr = N'(1) << ch; cc_wdata = W'(v);
        tick();
        cc_wr = '0;
    endtask

    task automatic sync_upd();
        while (!upd) tick();
        tick();
    endtask

    // Length of the next full ramp (cycles from wrap to wrap) and its index
    task automatic measure(output int len, output bit idx);
        sync_upd();
        idx = ramp_idx;
        len = 1;
        while (!upd) begin tick(); len++; end
    endtask

    initial begin
        int len;
        bit idx;
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(wo == '0, "R1 wo during reset", wo, 0);
        chk(ramp_idx == 1'b0, "R1 ramp_idx during reset", ramp_idx, 0);
        chk(upd == 1'b0, "R1 upd during reset", upd, 0);

        // Table of configurations against the reference model
        for (int k = 0; k < 8; k++) begin
            mode = CFG[k].mode;
            circ_en = CFG[k].circ;
            pol = CFG[k].pol;
            do_reset();
            wr_cc(0, CFG[k].c0);
            wr_cc(1, CFG[k].c1);
            wr_cc(2, CFG[k].c2);
            wr_cc(3, CFG[k].c3);
            wr_per(CFG[k].pa);
            sync_upd();
            if (CFG[k].circ) wr_per(CFG[k].pb);
            for (int c = 0; c < 60; c++) begin
                tick();
                chk(wo == m_wo(), "R2 R6 R8 R10 R11 wo vs model", wo, m_wo());
                chk(ramp_idx == m_idx, "R4 ramp_idx vs model", ramp_idx, m_idx);
                chk(upd == (m_cnt >= m_top()), "R3 upd vs model", upd, m_cnt >= m_top());
                if (mode == 2'd3) begin
                    // R10: two-channel variant, output 0 spans all of ramp A
                    chk(wo2[0] == ((!m_idx) ^ pol[0]), "R10 two-channel wo0",
                        wo2[0], (!m_idx) ^ pol[0]);
                end
            end
        end

        // R3: reset period 7 gives 8-cycle ramps
        mode = 2'd0; circ_en = 0; pol = '0;
        do_reset();
        measure(len, idx);
        chk(len == 8, "R3 ramp length with reset period", len, 8);

        // R7: circular period alternates 5 and 9
        mode = 2'd1; circ_en = 1;
        do_reset();
        wr_per(5);
        sync_upd();
        wr_per(9);
        measure(len, idx);
        chk(len == 10, "R7 first circular ramp length", len, 10);
        measure(len, idx);
        chk(len == 6, "R7 second circular ramp length", len, 6);
        measure(len, idx);
        chk(len == 10, "R7 third circular ramp length", len, 10);

        // R9: critical mode, ramp A top = cc0 (4), ramp B top = period (9)
        mode = 2'd3; circ_en = 0;
        do_reset();
        wr_cc(0, 4);
        wr_per(9);
        sync_upd();
        for (int r = 0; r < 3; r++) begin
            measure(len, idx);
            chk(len == (idx ? 10 : 5), "R9 critical ramp length", len, idx ? 10 : 5);
        end

        // R5: index commands
        mode = 2'd1; circ_en = 0;
        do_reset();
        idx_cmd = 2'd1;
        sync_upd();
        chk(ramp_idx == 1'b0, "R5 force A after update", ramp_idx, 0);
        sync_upd();
        chk(ramp_idx == 1'b0, "R5 force A repeated", ramp_idx, 0);
        idx_cmd = 2'd2;
        sync_upd();
        chk(ramp_idx == 1'b1, "R5 force B after update", ramp_idx, 1);
        idx_cmd = 2'd3;
        sync_upd();
        chk(ramp_idx == 1'b1, "R5 hold keeps B", ramp_idx, 1);
        idx_cmd = 2'd0;
        sync_upd();
        chk(ramp_idx == 1'b0, "R4 toggle back to A", ramp_idx, 0);
        tick();
        chk(ramp_idx == 1'b0, "R4 no change without update", ramp_idx, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule